// File: doc/BRIEF.md
# Transmit Phase Alignment Sequencer

This block runs in the system clock domain and steers a transmit clock phase interpolator. The goal is for a buffer fill-level phase detector to read half of its full-scale count. The sequencer does not move the interpolator or count fill-level samples itself. It issues step requests to an interpolator controller and waits for that controller's done pulse. It also starts measurements on a fill-level detector and waits for the detector's done flag. The controller reports its accumulated 7-bit phase, which wraps modulo 128.

In free mode the block first runs a coarse scan. This scan uses 8-unit steps and a detector window shortened by a factor of 128. When the reading changes side, a fine scan with 1-unit steps finds the crossing. In calibrated mode the block skips all measurement and walks the interpolator the short way around to a stored phase code. Once aligned, a rising edge on the realign input starts a new fine scan from the current phase. The aligned output is low for the whole procedure, so it can hold the user transmit logic in reset.

Top module: `tx_phase_align_seq`

## Requirements
- R1: While rst_ni is low, aligned_o, step_req_o and det_clear_o are low. The procedure starts by itself after rst_ni rises.
- R2: A step request is a one-cycle step_req_o pulse qualified by step_up_o (1 = increase phase) and step_size_o. No further step request or measurement starts until step_done_i has been seen.
- R3: Each measurement opens with a one-cycle det_clear_o pulse and then waits for det_done_i. The reading counts as high when det_count_i is at least half of det_target_o, including exact equality.
- R4: During the coarse scan det_target_o equals det_max_i shifted right by 7. During any fine scan it equals det_max_i.
- R5: In free mode a first measurement is taken at the starting phase. The block then steps up by 8 and measures after each step, until a reading lands on the other side of half-scale from the first one. It gives up after a full turn of 16 steps.
- R6: The fine scan after a coarse scan steps down by 1 and stops at the first reading whose side differs from the coarse end reading. The final phase is therefore one below the detector edge that the coarse scan crossed.
- R7: With cal_mode_i high at start, no measurement is made. Each step has size min(distance, 8). The step goes up when (cal_phase_i - phase) mod 128 is below 64 and down otherwise, with 64 itself going down. Alignment is declared as soon as the phase equals cal_phase_i, even with zero steps.
- R8: aligned_o is high only once a procedure has finished. No step request or detector clear is issued while it is high.
- R9: A rising edge on realign_i while aligned_o is high drops aligned_o in the next cycle and runs a fine scan from the current phase. Its direction comes from the edge slope learned in the last coarse scan, with a rising edge assumed if none was learned. It stops at the first change of side. A level held high does not start another scan.
- R10: Activity on realign_i while aligned_o is low has no effect on the procedure or its result.
- R11: Phase arithmetic wraps modulo 128, both in scans and in calibrated moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_mode_i | input | 1 | 1 = move to cal_phase_i instead of searching |
| cal_phase_i | input | 7 | Stored calibrated interpolator phase |
| det_max_i | input | 32 | Full-scale detector count (static) |
| realign_i | input | 1 | Rising edge requests a fine re-scan when aligned |
| aligned_o | output | 1 | Procedure finished |
| step_req_o | output | 1 | One-cycle step request to the interpolator controller |
| step_up_o | output | 1 | Step direction, 1 = increase |
| step_size_o | output | 4 | Step size in interpolator units |
| step_done_i | input | 1 | Controller finished the step |
| pi_phase_i | input | 7 | Accumulated interpolator phase |
| det_clear_o | output | 1 | One-cycle detector clear/start |
| det_target_o | output | 32 | Detector target count for the current window |
| det_done_i | input | 1 | Detector reached its target count |
| det_count_i | input | 32 | Detector accumulated reading |

## Verification
The bench models a detector whose reading flips at two edges 64 units apart. It starts scans exactly on an edge, just below zero, and on both slopes. A design that picked the wrong fine direction, or lost the learned slope before a realign, would run away from the edge and finish far from the expected phase. Calibrated moves cover wrap-around, the 64-unit tie and the zero-distance case, where a wrong short-way rule would show up as extra steps or a wrong direction. A detector reading exactly half-scale catches a strict comparison, which would never see a crossing. Realign pulses given before alignment would trigger a second scan in a design that latched them.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_CHK,
    ST_STEP,
    ST_STEP_WAIT,
    ST_MEAS_CLR,
    ST_MEAS_WAIT,
    ST_ALIGNED
  } seq_state_e;

  typedef enum logic [1:0] {
    SRCH_COARSE,
    SRCH_FINE,
    SRCH_CAL
  } srch_e;
endpackage

// File: rtl/tpa_half_cmp.sv
module tpa_half_cmp #(
  parameter int DET_W = 32
) (
  input  logic [DET_W-1:0] count_i,
  input  logic [DET_W-1:0] target_i,
  output logic             hi_o
);
  always_comb hi_o = (count_i >= (target_i >> 1));
endmodule

// File: rtl/tpa_rise_det.sv
module tpa_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= 1'b0;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/tpa_cal_dist.sv
module tpa_cal_dist #(
  parameter int PHASE_W  = 7,
  parameter int STEP_W   = 4,
  parameter int MAX_STEP = 8
) (
  input  logic [PHASE_W-1:0] target_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               zero_o,
  output logic               up_o,
  output logic [STEP_W-1:0]  size_o
);
  logic [PHASE_W-1:0] diff;
  logic [PHASE_W-1:0] mag;

  always_comb begin
    diff   = target_i - phase_i;
    zero_o = (diff == '0);
    // MSB clear: forward distance below half a turn; tie goes down
    up_o   = ~diff[PHASE_W-1];
    mag    = up_o ? diff : (PHASE_W'(0) - diff);
    size_o = (mag > PHASE_W'(MAX_STEP)) ? STEP_W'(MAX_STEP) : STEP_W'(mag);
  end
endmodule

// File: rtl/tx_phase_align_seq.sv
module tx_phase_align_seq #(
  parameter int PHASE_W     = 7,
  parameter int DET_W       = 32,
  parameter int STEP_W      = 4,
  parameter int COARSE_STEP = 8,
  parameter int FINE_STEP   = 1,
  parameter int SPEED_SHIFT = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cal_mode_i,
  input  logic [PHASE_W-1:0] cal_phase_i,
  input  logic [DET_W-1:0]   det_max_i,
  input  logic               realign_i,
  output logic               aligned_o,
  output logic               step_req_o,
  output logic               step_up_o,
  output logic [STEP_W-1:0]  step_size_o,
  input  logic               step_done_i,
  input  logic [PHASE_W-1:0] pi_phase_i,
  output logic               det_clear_o,
  output logic [DET_W-1:0]   det_target_o,
  input  logic               det_done_i,
  input  logic [DET_W-1:0]   det_count_i
);
  import tpa_pkg::*;

  localparam int PHASE_SPAN   = 1 << PHASE_W;
  localparam int COARSE_LIMIT = PHASE_SPAN / COARSE_STEP;
  localparam int FINE_LIMIT   = PHASE_SPAN;
  localparam int CNT_W        = $clog2(FINE_LIMIT + 1);

  seq_state_e         state_q, state_d;
  srch_e              srch_q, srch_d;
  logic               first_q, first_d;
  logic               ref_hi_q, ref_hi_d;
  logic               rising_q, rising_d;
  logic               up_q, up_d;
  logic [STEP_W-1:0]  size_q, size_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  logic               meas_hi;
  logic               realign_rise;
  logic               cal_zero;
  logic               cal_up;
  logic [STEP_W-1:0]  cal_size;
  logic               limit_hit;

  tpa_half_cmp #(.DET_W(DET_W)) u_cmp (
    .count_i  (det_count_i),
    .target_i (det_target_o),
    .hi_o     (meas_hi)
  );

  tpa_rise_det u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (realign_i),
    .rise_o (realign_rise)
  );

  tpa_cal_dist #(
    .PHASE_W  (PHASE_W),
    .STEP_W   (STEP_W),
    .MAX_STEP (COARSE_STEP)
  ) u_dist (
    .target_i (cal_phase_i),
    .phase_i  (pi_phase_i),
    .zero_o   (cal_zero),
    .up_o     (cal_up),
    .size_o   (cal_size)
  );

  assign limit_hit = (srch_q == SRCH_COARSE) ? (cnt_q >= CNT_W'(COARSE_LIMIT))
                                             : (cnt_q >= CNT_W'(FINE_LIMIT));

  always_comb begin
    state_d  = state_q;
    srch_d   = srch_q;
    first_d  = first_q;
    ref_hi_d = ref_hi_q;
    rising_d = rising_q;
    up_d     = up_q;
    size_d   = size_q;
    cnt_d    = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cal_mode_i) begin
          srch_d  = SRCH_CAL;
          state_d = ST_CAL_CHK;
        end else begin
          srch_d  = SRCH_COARSE;
          first_d = 1'b1;
          state_d = ST_MEAS_CLR;
        end
      end
      ST_CAL_CHK: begin
        if (cal_zero) begin
          state_d = ST_ALIGNED;
        end else begin
          up_d    = cal_up;
          size_d  = cal_size;
          state_d = ST_STEP;
        end
      end
      ST_STEP: begin
        cnt_d   = cnt_q + CNT_W'(1);
        state_d = ST_STEP_WAIT;
      end
      ST_STEP_WAIT: begin
        if (step_done_i) state_d = (srch_q == SRCH_CAL) ? ST_CAL_CHK : ST_MEAS_CLR;
      end
      ST_MEAS_CLR: begin
        state_d = ST_MEAS_WAIT;
      end
      ST_MEAS_WAIT: begin
        if (det_done_i) begin
          if (first_q) begin
            ref_hi_d = meas_hi;
            first_d  = 1'b0;
            cnt_d    = '0;
            if (srch_q == SRCH_COARSE) begin
              up_d   = 1'b1;
              size_d = STEP_W'(COARSE_STEP);
            end else begin
              // move so the reading heads back across half-scale
              up_d   = (meas_hi != rising_q);
              size_d = STEP_W'(FINE_STEP);
            end
            state_d = ST_STEP;
          end else if (meas_hi != ref_hi_q) begin
            if (srch_q == SRCH_COARSE) begin
              rising_d = meas_hi;
              srch_d   = SRCH_FINE;
              ref_hi_d = meas_hi;
              cnt_d    = '0;
              up_d     = 1'b0;
              size_d   = STEP_W'(FINE_STEP);
              state_d  = ST_STEP;
            end else begin
              state_d  = ST_ALIGNED;
            end
          end else if (limit_hit) begin
            if (srch_q == SRCH_COARSE) begin
              srch_d   = SRCH_FINE;
              ref_hi_d = meas_hi;
              cnt_d    = '0;
              up_d     = (meas_hi != rising_q);
              size_d   = STEP_W'(FINE_STEP);
              state_d  = ST_STEP;
            end else begin
              state_d  = ST_ALIGNED;
            end
          end else begin
            state_d = ST_STEP;
          end
        end
      end
      ST_ALIGNED: begin
        if (realign_rise) begin
          srch_d  = SRCH_FINE;
          first_d = 1'b1;
          state_d = ST_MEAS_CLR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      srch_q   <= SRCH_COARSE;
      first_q  <= 1'b1;
      ref_hi_q <= 1'b0;
      rising_q <= 1'b1;
      up_q     <= 1'b1;
      size_q   <= '0;
      cnt_q    <= '0;
    end else begin
      state_q  <= state_d;
      srch_q   <= srch_d;
      first_q  <= first_d;
      ref_hi_q <= ref_hi_d;
      rising_q <= rising_d;
      up_q     <= up_d;
      size_q   <= size_d;
      cnt_q    <= cnt_d;
    end
  end

  assign aligned_o    = (state_q == ST_ALIGNED);
  assign step_req_o   = (state_q == ST_STEP);
  assign step_up_o    = up_q;
  assign step_size_o  = size_q;
  assign det_clear_o  = (state_q == ST_MEAS_CLR);
  assign det_target_o = (srch_q == SRCH_COARSE) ? (det_max_i >> SPEED_SHIFT) : det_max_i;
endmodule

// File: rtl/tx_phase_align_seq_chk.sv
module tx_phase_align_seq_chk #(
  parameter int DET_W       = 32,
  parameter int STEP_W      = 4,
  parameter int MAX_STEP    = 8,
  parameter int SPEED_SHIFT = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              realign_i,
  input logic              aligned_o,
  input logic              step_req_o,
  input logic [STEP_W-1:0] step_size_o,
  input logic              det_clear_o,
  input logic [DET_W-1:0]  det_target_o,
  input logic [DET_W-1:0]  det_max_i
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!aligned_o && !step_req_o && !det_clear_o));

  assert_step_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_req_o |=> !step_req_o);

  assert_clear_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_clear_o |=> !det_clear_o);

  assert_target_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_clear_o |-> (det_target_o == det_max_i || det_target_o == (det_max_i >> SPEED_SHIFT)));

  assert_step_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_req_o |-> (step_size_o != '0 && step_size_o <= STEP_W'(MAX_STEP)));

  assert_aligned_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o |-> (!step_req_o && !det_clear_o));

  assert_realign_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned_o && realign_i && !$past(realign_i)) |=> !aligned_o);
endmodule

bind tx_phase_align_seq tx_phase_align_seq_chk #(
  .DET_W       (DET_W),
  .STEP_W      (STEP_W),
  .MAX_STEP    (COARSE_STEP),
  .SPEED_SHIFT (SPEED_SHIFT)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .realign_i    (realign_i),
  .aligned_o    (aligned_o),
  .step_req_o   (step_req_o),
  .step_size_o  (step_size_o),
  .det_clear_o  (det_clear_o),
  .det_target_o (det_target_o),
  .det_max_i    (det_max_i)
);

// File: tb/tx_phase_align_seq_tb_top.sv
`timescale 1ns/1ps
module tx_phase_align_seq_tb_top;
  localparam logic [31:0] DET_MAX = 32'h0002_0000;

  typedef struct packed {
    logic       cal;
    logic [6:0] start;
    logic [6:0] e0;
    logic [6:0] cal_ph;
    logic [6:0] exp_ph;
    logic [7:0] na;  // free: up-8 steps, cal: up steps
    logic [7:0] nb;  // free: down-1 steps, cal: down steps
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 7'd0,   7'd37, 7'd0,   7'd36,  8'd5, 8'd4},
    '{1'b0, 7'd50,  7'd0,  7'd0,   7'd63,  8'd2, 8'd3},
    '{1'b0, 7'd120, 7'd10, 7'd0,   7'd9,   8'd3, 8'd7},
    '{1'b0, 7'd37,  7'd37, 7'd0,   7'd100, 8'd8, 8'd1},
    '{1'b1, 7'd0,   7'd0,  7'd20,  7'd20,  8'd3, 8'd0},
    '{1'b1, 7'd0,   7'd0,  7'd120, 7'd120, 8'd0, 8'd1},
    '{1'b1, 7'd5,   7'd0,  7'd5,   7'd5,   8'd0, 8'd0},
    '{1'b1, 7'd100, 7'd0,  7'd36,  7'd36,  8'd0, 8'd8},
    '{1'b1, 7'd125, 7'd0,  7'd3,   7'd3,   8'd1, 8'd0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cal_mode_i = 1'b0;
  logic [6:0]  cal_phase_i = '0;
  logic [31:0] det_max_i = DET_MAX;
  logic        realign_i = 1'b0;
  logic        aligned_o, step_req_o, step_up_o, det_clear_o;
  logic [3:0]  step_size_o;
  logic        step_done_i = 1'b0;
  logic [6:0]  pi_phase_i;
  logic [31:0] det_target_o;
  logic        det_done_i = 1'b0;
  logic [31:0] det_count_i = '0;

  always #2.5 clk_i = ~clk_i;

  tx_phase_align_seq dut_i (
    .clk_i, .rst_ni, .cal_mode_i, .cal_phase_i, .det_max_i, .realign_i,
    .aligned_o, .step_req_o, .step_up_o, .step_size_o, .step_done_i,
    .pi_phase_i, .det_clear_o, .det_target_o, .det_done_i, .det_count_i
  );

  int checks = 0, fails = 0;
  logic [6:0]  phase_m = '0, e0_m = '0;
  bit          exact_half = 0;
  int          sdly = 0, ddly = 0;
  bit          busy = 0, prev_clear = 0, s_up = 0;
  logic [3:0]  s_sz = '0;
  logic [31:0] tgt_m = '0, first_tgt = '0, last_tgt = '0;
  int n_req, n_up, n_dn, n_up8, n_dn1, n_clear;
  int v_r2 = 0, v_r3 = 0, v_r8 = 0;

  assign pi_phase_i = phase_m;

  function automatic bit meas_hi(input logic [6:0] p);
    logic [6:0] d;
    d = p - e0_m;
    return !d[6];
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // interpolator controller and fill-level detector models
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      sdly = 0; ddly = 0; busy = 0; prev_clear = 0;
      step_done_i = 0; det_done_i = 0; det_count_i = '0;
    end else begin
      step_done_i = 0;
      if (sdly != 0) begin
        sdly--;
        if (sdly == 0) begin
          phase_m = s_up ? phase_m + 7'(s_sz) : phase_m - 7'(s_sz);
          step_done_i = 1;
          busy = 0;
        end
      end
      if (step_req_o) begin
        if (busy) v_r2++;
        busy = 1; sdly = 2; s_up = step_up_o; s_sz = step_size_o;
        n_req++;
        if (step_up_o) n_up++; else n_dn++;
        if (step_up_o && step_size_o == 4'd8) n_up8++;
        if (!step_up_o && step_size_o == 4'd1) n_dn1++;
      end
      if (det_clear_o) begin
        if (prev_clear || busy) v_r3++;
        det_done_i = 0; ddly = 3; tgt_m = det_target_o;
        if (n_clear == 0) first_tgt = tgt_m;
        last_tgt = tgt_m;
        n_clear++;
      end else if (ddly != 0) begin
        ddly--;
        if (ddly == 0) begin
          det_count_i = meas_hi(phase_m) ? (exact_half ? (tgt_m >> 1) : tgt_m - (tgt_m >> 2))
                                         : (tgt_m >> 2);
          det_done_i = 1;
        end
      end
      if (aligned_o && (step_req_o || det_clear_o)) v_r8++;
      prev_clear = det_clear_o;
    end
  end

  task automatic clr_counts();
    n_req = 0; n_up = 0; n_dn = 0; n_up8 = 0; n_dn1 = 0; n_clear = 0;
  endtask

  task automatic start_run(input bit cal, input logic [6:0] start, input logic [6:0] e0, input logic [6:0] cph);
    @(negedge clk_i); #1;
    rst_ni = 0; realign_i = 0;
    cal_mode_i = cal; cal_phase_i = cph; phase_m = start; e0_m = e0;
    clr_counts();
    repeat (3) @(negedge clk_i);
    check(!aligned_o && !step_req_o && !det_clear_o, "R1", "outputs in reset",
          {aligned_o, step_req_o, det_clear_o}, 0);
    #1;
    rst_ni = 1;
    realign_i = 1;  // R10: edge while not aligned
    repeat (3) @(negedge clk_i);
    #1 realign_i = 0;
  endtask

  task automatic wait_aligned(input string req);
    bit ok;
    ok = 0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk_i);
      if (aligned_o) begin ok = 1; break; end
    end
    check(ok, req, "aligned reached", ok, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      string rq;
      int req_before;
      v = VECS[i];
      start_run(v.cal, v.start, v.e0, v.cal_ph);
      wait_aligned("R8");
      rq = (i == 2 || i == 8) ? "R11" : (v.cal ? "R7" : "R6");
      check(pi_phase_i == v.exp_ph, rq, "final phase", pi_phase_i, v.exp_ph);
      if (!v.cal) begin
        check(n_up8 == int'(v.na), "R5", "coarse up-8 steps", n_up8, v.na);
        check(n_dn1 == int'(v.nb), "R6", "fine down-1 steps", n_dn1, v.nb);
        check(n_req == int'(v.na) + int'(v.nb), "R6", "total steps", n_req, v.na + v.nb);
        check(first_tgt == (DET_MAX >> 7), "R4", "coarse target", first_tgt, DET_MAX >> 7);
        check(last_tgt == DET_MAX, "R4", "fine target", last_tgt, DET_MAX);
      end else begin
        check(n_up == int'(v.na), "R7", "up steps", n_up, v.na);
        check(n_dn == int'(v.nb), "R7", "down steps", n_dn, v.nb);
        check(n_clear == 0, "R7", "measurements in cal mode", n_clear, 0);
      end
      req_before = n_req;
      repeat (40) @(negedge clk_i);
      check(aligned_o && n_req == req_before, "R10", "no scan from early realign",
            n_req, req_before);
    end

    // R9: rising slope learned, edge drifts up to 40
    start_run(0, 7'd0, 7'd37, 7'd0);
    wait_aligned("R8");
    @(negedge clk_i); #1;
    e0_m = 7'd40; clr_counts(); realign_i = 1;
    @(negedge clk_i);
    check(!aligned_o, "R9", "aligned drops after realign edge", aligned_o, 0);
    wait_aligned("R9");
    check(pi_phase_i == 7'd40, "R9", "realign phase rising slope", pi_phase_i, 40);
    check(n_up == 4 && n_req == 4, "R9", "realign up steps", n_up, 4);
    check(first_tgt == DET_MAX, "R4", "realign uses full target", first_tgt, DET_MAX);
    repeat (60) @(negedge clk_i);
    check(aligned_o && n_req == 4, "R9", "held realign level no retrigger", n_req, 4);

    // R9: falling slope learned, edge drifts down to 60
    start_run(0, 7'd50, 7'd0, 7'd0);
    wait_aligned("R8");
    check(pi_phase_i == 7'd63, "R6", "falling edge phase", pi_phase_i, 63);
    @(negedge clk_i); #1;
    e0_m = 7'd124; clr_counts(); realign_i = 1;
    wait_aligned("R9");
    check(pi_phase_i == 7'd59, "R9", "realign phase falling slope", pi_phase_i, 59);
    check(n_dn == 4 && n_req == 4, "R9", "realign down steps", n_dn, 4);
    #1 realign_i = 0;

    // R3: reading of exactly half-scale counts as high
    exact_half = 1;
    start_run(0, 7'd0, 7'd37, 7'd0);
    wait_aligned("R3");
    check(pi_phase_i == 7'd36, "R3", "half-scale equality", pi_phase_i, 36);
    exact_half = 0;

    check(v_r2 == 0, "R2", "request or clear while step pending", v_r2, 0);
    check(v_r3 == 0, "R3", "clear pulse longer than one cycle", v_r3, 0);
    check(v_r8 == 0, "R8", "activity while aligned", v_r8, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule